// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Code Latch

This block holds the output codes of two converter channels behind a byte-wide register write port. Each channel has a 16-bit input register and a 16-bit active register. Software loads the input registers, either one channel at a time or by broadcasting one code to every selected channel. The active registers, which drive the converter, change only on a transfer. A transfer is started by a masked software load write or by a falling edge on an asynchronous active-low load pin. A channel-select register limits which channels take part in broadcasts and transfers. A direct-write path sets an active register immediately. A power-down register holds per-channel converter and amplifier disable bits.

Multi-byte registers are three bytes wide and are written high byte first, at descending addresses. The high byte is staged. The second byte commits the full 16-bit code, and the lowest byte is padding. Because of this layout, a single descending burst can load channel 1, then channel 0, then the software load mask, so both channels switch in the same cycle. Reads are combinational through a separate read address.

Top module: `dac_code_latch`

## Requirements
- R1: After reset all input and active codes are 0, the select register reads 0, both power-down outputs are 0, and the load-pin synchroniser idles high.
- R2: The input register of channel n occupies byte addresses 0x48+3n (code bits 15:8, staged), 0x47+3n (bits 7:0, commits the code) and 0x46+3n (padding: writes ignored, reads 0). Writing it leaves the active register unchanged.
- R3: Writing the broadcast register (0x44 high byte, then 0x43 to commit) loads the code into the input register of every channel whose select bit is set. Unselected channels keep their input code.
- R4: Writing mask m to address 0x45 copies input to active, one clock after the write, for each channel n with bit n of m set and select bit n set. Other channels are unaffected.
- R5: A falling edge on ldac_ni passes a two-flop synchroniser and copies input to active for all selected channels. The copy happens on the third rising clock edge after the fall and not before.
- R6: A load-pin pulse causes exactly one transfer, however long the pin is held low. The rising edge has no effect.
- R7: The select register at 0x41 holds bit n for channel n and reads back on those bits.
- R8: The active register of channel n is written directly at 0x3A+3n (high byte) and 0x39+3n (commit), and reads back there. Such a write leaves the input register unchanged.
- R9: A descending seven-byte burst from 0x4B (channel 1 code, pad, channel 0 code, pad, load mask 0x03) leaves both active codes unchanged until the mask byte, then updates both in the same cycle.
- R10: Register 0x18 drives the converter power-down bits from data bits 5:4 and the amplifier power-down bits from bits 1:0. Other bits are dropped, and the register reads back in the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | One-cycle byte write strobe from the serial front end |
| wr_addr_i | input | 7 | Byte address of the write |
| wr_data_i | input | 8 | Byte written |
| rd_addr_i | input | 7 | Byte address to read |
| rd_data_o | output | 8 | Combinational read data |
| ldac_ni | input | 1 | Asynchronous active-low load pin |
| act_code_o | output | 32 | Active codes, channel n in bits 16n+15:16n |
| dac_pd_o | output | 2 | Per-channel converter power-down |
| amp_pd_o | output | 2 | Per-channel amplifier power-down |

## Verification
Transfers are tried with the select register at 0, 1, 2 and 3, and with software masks that do and do not overlap it. This separates the software mask from the select gate. The broadcast path is tried with one channel deselected, to show that it only touches selected input registers. The load pin is sampled one and two cycles after its fall, which pins down the synchroniser depth. The pin is then held low while the input changes, which separates edge detection from level sensing. A full descending burst is checked just before and after its last byte, to show that both channels switch together. Direct active writes are followed by input readback, to show the two paths stay apart.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CODE_W     = 2 * BYTE_W;
  localparam int unsigned REG_STRIDE = 3;

  localparam logic [ADDR_W-1:0] A_IN_TOP0  = 7'h48;
  localparam logic [ADDR_W-1:0] A_ACT_TOP0 = 7'h3A;
  localparam logic [ADDR_W-1:0] A_BCAST    = 7'h44;
  localparam logic [ADDR_W-1:0] A_SW_LOAD  = 7'h45;
  localparam logic [ADDR_W-1:0] A_SEL      = 7'h41;
  localparam logic [ADDR_W-1:0] A_PD       = 7'h18;

  // highest (high-byte) address of channel n's input register
  function automatic logic [ADDR_W-1:0] in_top(int unsigned n);
    return A_IN_TOP0 + ADDR_W'(REG_STRIDE * n);
  endfunction

  function automatic logic [ADDR_W-1:0] act_top(int unsigned n);
    return A_ACT_TOP0 + ADDR_W'(REG_STRIDE * n);
  endfunction
endpackage

// File: rtl/dcl_ldac_sync.sv
module dcl_ldac_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ldac_ni,
  output logic fall_o
);
  logic [SYNC_N:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[SYNC_N-1:0], ldac_ni};
  end

  assign fall_o = sh_q[SYNC_N] & ~sh_q[SYNC_N-1];

  // R6: one transfer strobe per pulse
  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dcl_decode.sv
module dcl_decode
  import dcl_pkg::*;
#(
  parameter int unsigned NCH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [CODE_W-1:0] code_o,
  output logic [NCH-1:0]    in_load_o,
  output logic [NCH-1:0]    act_load_o,
  output logic [NCH-1:0]    sw_xfer_o,
  output logic [NCH-1:0]    sel_o,
  output logic [NCH-1:0]    dac_pd_o,
  output logic [NCH-1:0]    amp_pd_o
);
  logic [BYTE_W-1:0] hi_q;
  logic [NCH-1:0]    sel_q, dac_pd_q, amp_pd_q;
  logic              is_top;

  always_comb begin
    in_load_o  = '0;
    act_load_o = '0;
    sw_xfer_o  = '0;
    is_top     = 1'b0;
    if (wr_en_i) begin
      for (int unsigned n = 0; n < NCH; n++) begin
        if (wr_addr_i == in_top(n) - 7'd1)  in_load_o[n]  = 1'b1;
        if (wr_addr_i == act_top(n) - 7'd1) act_load_o[n] = 1'b1;
        if (wr_addr_i == in_top(n) || wr_addr_i == act_top(n)) is_top = 1'b1;
      end
      if (wr_addr_i == A_BCAST)         is_top = 1'b1;
      if (wr_addr_i == A_BCAST - 7'd1)  in_load_o = in_load_o | sel_q;
      if (wr_addr_i == A_SW_LOAD)       sw_xfer_o = wr_data_i[NCH-1:0] & sel_q;
    end
  end

  assign code_o = {hi_q, wr_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= '0;
      sel_q    <= '0;
      dac_pd_q <= '0;
      amp_pd_q <= '0;
    end else if (wr_en_i) begin
      if (is_top)               hi_q  <= wr_data_i;
      if (wr_addr_i == A_SEL)   sel_q <= wr_data_i[NCH-1:0];
      if (wr_addr_i == A_PD) begin
        dac_pd_q <= wr_data_i[4 +: NCH];
        amp_pd_q <= wr_data_i[0 +: NCH];
      end
    end
  end

  assign sel_o    = sel_q;
  assign dac_pd_o = dac_pd_q;
  assign amp_pd_o = amp_pd_q;

  // R4: software transfer never reaches a deselected channel
  p_sw_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_xfer_o & ~sel_o) == '0);
  // R7: select changes only on its own write
  p_sel_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == A_SEL) |=> $stable(sel_o));
endmodule

// File: rtl/dcl_channel.sv
module dcl_channel
  import dcl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              in_load_i,
  input  logic              act_load_i,
  input  logic              xfer_i,
  output logic [CODE_W-1:0] in_o,
  output logic [CODE_W-1:0] act_o
);
  logic [CODE_W-1:0] in_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      act_q <= '0;
    end else begin
      if (in_load_i) in_q <= code_i;
      // direct write takes precedence over a transfer in the same cycle
      if (act_load_i)  act_q <= code_i;
      else if (xfer_i) act_q <= in_q;
    end
  end

  assign in_o  = in_q;
  assign act_o = act_q;

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_i && !act_load_i) |=> $stable(act_o));
  p_xfer_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !act_load_i) |=> act_o == $past(in_o));
  p_direct_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_load_i |=> act_o == $past(code_i));
  p_in_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_load_i |=> $stable(in_o));
endmodule

// File: rtl/dac_code_latch.sv
module dac_code_latch
  import dcl_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [BYTE_W-1:0]           wr_data_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [BYTE_W-1:0]           rd_data_o,
  input  logic                        ldac_ni,
  output logic [NCH-1:0][CODE_W-1:0]  act_code_o,
  output logic [NCH-1:0]              dac_pd_o,
  output logic [NCH-1:0]              amp_pd_o
);
  logic [CODE_W-1:0]           code;
  logic [NCH-1:0]              in_load, act_load, sw_xfer, sel, xfer;
  logic [NCH-1:0][CODE_W-1:0]  in_code;
  logic                        hw_fall;

  dcl_decode #(.NCH(NCH)) u_decode (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .code_o(code), .in_load_o(in_load), .act_load_o(act_load),
    .sw_xfer_o(sw_xfer), .sel_o(sel), .dac_pd_o, .amp_pd_o
  );

  dcl_ldac_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .ldac_ni, .fall_o(hw_fall)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign xfer[n] = sw_xfer[n] | (hw_fall & sel[n]);
    dcl_channel u_ch (
      .clk_i, .rst_ni, .code_i(code),
      .in_load_i(in_load[n]), .act_load_i(act_load[n]), .xfer_i(xfer[n]),
      .in_o(in_code[n]), .act_o(act_code_o[n])
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_SEL) rd_data_o[NCH-1:0] = sel;
    if (rd_addr_i == A_PD) begin
      rd_data_o[4 +: NCH] = dac_pd_o;
      rd_data_o[0 +: NCH] = amp_pd_o;
    end
    for (int unsigned n = 0; n < NCH; n++) begin
      if (rd_addr_i == in_top(n))          rd_data_o = in_code[n][CODE_W-1:BYTE_W];
      if (rd_addr_i == in_top(n) - 7'd1)   rd_data_o = in_code[n][BYTE_W-1:0];
      if (rd_addr_i == act_top(n))         rd_data_o = act_code_o[n][CODE_W-1:BYTE_W];
      if (rd_addr_i == act_top(n) - 7'd1)  rd_data_o = act_code_o[n][BYTE_W-1:0];
    end
  end

  p_pd_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_PD) |=>
      (dac_pd_o == $past(wr_data_i[4 +: NCH]) && amp_pd_o == $past(wr_data_i[0 +: NCH])));
  p_pd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == A_PD) |=> ($stable(dac_pd_o) && $stable(amp_pd_o)));
endmodule

// File: tb/dac_code_latch_tb.sv
module dac_code_latch_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [6:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [6:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o;
  logic        ldac_ni = 1'b1;
  logic [1:0][15:0] act_code_o;
  logic [1:0]  dac_pd_o, amp_pd_o;

  always #2.5 clk = ~clk;

  dac_code_latch u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .ldac_ni, .act_code_o, .dac_pd_o, .amp_pd_o
  );

  typedef struct { int kind; logic [15:0] e0; logic [15:0] e1; string tag; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // monitor: compares queued expectations away from the clock edge
  initial forever begin
    @(posedge clk); #2;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      case (it.kind)
        0: if (act_code_o[0] !== it.e0 || act_code_o[1] !== it.e1) begin
             n_fail++;
             $display("FAIL %s: active got %h/%h exp %h/%h", it.tag,
                      act_code_o[0], act_code_o[1], it.e0, it.e1);
           end
        1: if (rd_data_o !== it.e0[7:0]) begin
             n_fail++;
             $display("FAIL %s: read got %h exp %h", it.tag, rd_data_o, it.e0[7:0]);
           end
        default: if ({dac_pd_o, amp_pd_o} !== it.e0[3:0]) begin
             n_fail++;
             $display("FAIL %s: pd got %b exp %b", it.tag, {dac_pd_o, amp_pd_o}, it.e0[3:0]);
           end
      endcase
    end
  end

  task automatic push(int kind, logic [15:0] e0, logic [15:0] e1, logic [6:0] ra, string tag);
    item_t it;
    @(negedge clk);
    rd_addr_i = ra;
    it.kind = kind; it.e0 = e0; it.e1 = e1; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic exp_act(logic [15:0] a0, logic [15:0] a1, string tag);
    push(0, a0, a1, rd_addr_i, tag);
  endtask
  task automatic exp_rd(logic [6:0] a, logic [7:0] v, string tag);
    push(1, {8'h00, v}, 16'h0, a, tag);
  endtask
  task automatic exp_pd(logic [3:0] v, string tag);
    push(2, {12'h0, v}, 16'h0, rd_addr_i, tag);
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask
  task automatic wr16(logic [6:0] top, logic [15:0] c);
    wr(top, c[15:8]);
    wr(top - 7'd1, c[7:0]);
    wr(top - 7'd2, 8'hAA);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1
    exp_act(16'h0, 16'h0, "R1 active reset");
    exp_rd(7'h41, 8'h00, "R1 select reset");
    exp_pd(4'b0000, "R1 pd reset");
    exp_rd(7'h48, 8'h00, "R1 input reset");
    // R2
    wr16(7'h48, 16'h1234);
    exp_rd(7'h48, 8'h12, "R2 high byte");
    exp_rd(7'h47, 8'h34, "R2 low byte");
    exp_rd(7'h46, 8'h00, "R2 pad ignored");
    exp_act(16'h0, 16'h0, "R2 active untouched");
    // R4 with empty select
    wr(7'h45, 8'h03);
    exp_act(16'h0, 16'h0, "R4 deselected no transfer");
    // R7
    wr(7'h41, 8'h03);
    exp_rd(7'h41, 8'h03, "R7 select readback");
    wr(7'h45, 8'h01);
    exp_act(16'h1234, 16'h0, "R4 masked channel only");
    // R3
    wr16(7'h44, 16'hBEEF);
    exp_rd(7'h4B, 8'hBE, "R3 broadcast ch1");
    wr(7'h45, 8'h03);
    exp_act(16'hBEEF, 16'hBEEF, "R3 broadcast both");
    wr(7'h41, 8'h02);
    wr16(7'h44, 16'h5555);
    exp_rd(7'h48, 8'hBE, "R3 unselected kept");
    exp_rd(7'h4A, 8'h55, "R3 selected loaded");
    wr(7'h41, 8'h03);
    wr(7'h45, 8'h03);
    exp_act(16'hBEEF, 16'h5555, "R4 both transfer");
    // R9 descending burst
    wr(7'h4B, 8'hA1); wr(7'h4A, 8'hB2); wr(7'h49, 8'h00);
    wr(7'h48, 8'hC3); wr(7'h47, 8'hD4); wr(7'h46, 8'h00);
    exp_act(16'hBEEF, 16'h5555, "R9 before mask byte");
    wr(7'h45, 8'h03);
    exp_act(16'hC3D4, 16'hA1B2, "R9 both together");
    // R8
    wr(7'h3A, 8'h0F); wr(7'h39, 8'h0F);
    exp_act(16'h0F0F, 16'hA1B2, "R8 direct ch0");
    exp_rd(7'h3A, 8'h0F, "R8 active readback");
    exp_rd(7'h48, 8'hC3, "R8 input kept");
    wr(7'h3D, 8'h77); wr(7'h3C, 8'h88);
    exp_act(16'h0F0F, 16'h7788, "R8 direct ch1");
    exp_rd(7'h3C, 8'h88, "R8 ch1 low readback");
    // R5
    wr16(7'h48, 16'h1111);
    wr16(7'h4B, 16'h2222);
    wr(7'h41, 8'h01);
    @(negedge clk); ldac_ni = 1'b0;
    exp_act(16'h0F0F, 16'h7788, "R5 not before synchroniser");
    exp_act(16'h1111, 16'h7788, "R5 selected channel only");
    repeat (3) @(negedge clk); ldac_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R6
    wr(7'h41, 8'h03);
    @(negedge clk); ldac_ni = 1'b0;
    repeat (6) @(negedge clk);
    exp_act(16'h1111, 16'h2222, "R5 both selected");
    wr16(7'h4B, 16'h3333);
    repeat (6) @(negedge clk);
    exp_act(16'h1111, 16'h2222, "R6 held low no retrigger");
    ldac_ni = 1'b1;
    repeat (6) @(negedge clk);
    exp_act(16'h1111, 16'h2222, "R6 rising edge no effect");
    // R10
    wr(7'h18, 8'hFF);
    exp_pd(4'b1111, "R10 all set");
    exp_rd(7'h18, 8'h33, "R10 readback");
    wr(7'h18, 8'h21);
    exp_pd(4'b1001, "R10 mixed");
    exp_rd(7'h18, 8'h21, "R10 mixed readback");
    wr(7'h18, 8'hCC);
    exp_pd(4'b0000, "R10 other bits dropped");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule